// File: doc/BRIEF.md
# Flash Write-Enable Status Logic

This block sits beside the command decoder of a serial flash front end and owns the write-enable latch together with a few related status bits. The decoder sends it one-cycle pulses: opcode fully shifted in (with the opcode byte and a flag saying the command modifies the array or the protection state), operation completed, operation aborted, hold-induced abort, and chip select returning high. From these the block sets and clears the latch and tells the decoder, one cycle after the opcode, whether a modifying command may go ahead.

A second bit enables a soft reset command. It is written only by the second status-byte write and is never touched by the soft reset itself. The block also reports whether the write-protect pin is held active, synchronised into the clock domain, and a two-bit summary of a per-sector protection vector.

Top module: `flash_wel_status`

## Requirements
- R1: While reset is active and until it has been released, wel, rst_en, mod_grant, mod_reject and soft_rst are 0 and wp_stat is 0 with the pin high.
- R2: A Write Enable (opcode 0x06) whose opcode was received in the current frame sets wel on the cycle after op_complete; a Write Disable (0x04) so received clears wel on op_complete; an abort of either leaves wel unchanged.
- R3: One cycle after opc_done with opc_is_mod=1, mod_grant pulses if wel was 1, otherwise mod_reject pulses; never both.
- R4: A modifying command whose opcode was received in the current frame clears wel on the cycle after either op_complete or op_abort.
- R5: An op_complete or op_abort arriving in a frame in which no opc_done has been seen since the last cs_rise leaves wel unchanged.
- R6: hold_abort clears wel on the next cycle regardless of frame state.
- R7: The soft reset opcode (parameter RST_OPC, default 0xF0) with rst_en=0 produces no soft_rst pulse and leaves wel unchanged; with rst_en=1 it pulses soft_rst and clears wel one cycle after opc_done, and rst_en keeps its value.
- R8: rst_en takes sr2_din on the cycle after sr2_wr and changes at no other time.
- R9: swp_sum is 00 when no bit of sect_prot is set, 11 when every bit is set, and 01 otherwise, following sect_prot in the same cycle.
- R10: wp_stat equals the inverse of the active-low wp_pin_n, delayed by SYNC_STAGES clock edges.
- R11: Completion or abort of an opcode of any other class (not modifying, 0x06, 0x04 or RST_OPC) leaves wel unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low power-on reset |
| opc_done | input | 1 | Pulse: whole opcode shifted in |
| opc_byte | input | 8 | Opcode value, valid with opc_done |
| opc_is_mod | input | 1 | Opcode belongs to the modifying class |
| op_complete | input | 1 | Pulse: current operation finished |
| op_abort | input | 1 | Pulse: current operation aborted |
| hold_abort | input | 1 | Pulse: abort caused by a hold condition |
| cs_rise | input | 1 | Pulse: chip select deasserted, frame ends |
| sr2_wr | input | 1 | Pulse: second status byte written |
| sr2_din | input | 1 | Reset-enable value carried by that write |
| wp_pin_n | input | 1 | Write-protect pin, active low, asynchronous |
| sect_prot | input | NSECT | Per-sector protection flags |
| wel | output | 1 | Write-enable latch |
| rst_en | output | 1 | Soft reset enable bit |
| wp_stat | output | 1 | Write-protect pin is asserted |
| swp_sum | output | 2 | Protection summary: 00 none, 01 some, 11 all |
| mod_grant | output | 1 | Pulse: modifying command accepted |
| mod_reject | output | 1 | Pulse: modifying command refused |
| soft_rst | output | 1 | Pulse: soft reset executes |

## Verification
The hardest case to reach is an abort that arrives with the latch at 1 but without a whole opcode in the current frame, since the decoder normally follows opc_done with completion. The bench builds every combination of starting latch value, opcode class, end event and frame qualification: it first forces the latch through a Write Enable or Write Disable frame, then either sends the opcode or closes the previous frame with cs_rise so that the following event lands unqualified. The expected latch value for each of these 32 cases is derived from the rules alone.

// File: rtl/flash_wel_pkg.sv
package flash_wel_pkg;

  typedef enum logic [2:0] {
    KIND_NONE  = 3'd0,
    KIND_WREN  = 3'd1,
    KIND_WRDI  = 3'd2,
    KIND_MOD   = 3'd3,
    KIND_RST   = 3'd4,
    KIND_OTHER = 3'd5
  } cmd_kind_e;

  typedef enum logic [1:0] {
    SWP_NONE = 2'b00,
    SWP_SOME = 2'b01,
    SWP_ALL  = 2'b11
  } swp_e;

  function automatic cmd_kind_e classify(input logic is_mod, input logic [7:0] opc,
                                         input logic [7:0] wren_opc,
                                         input logic [7:0] wrdi_opc,
                                         input logic [7:0] rst_opc);
    cmd_kind_e k;
    if (is_mod)              k = KIND_MOD;
    else if (opc == wren_opc) k = KIND_WREN;
    else if (opc == wrdi_opc) k = KIND_WRDI;
    else if (opc == rst_opc)  k = KIND_RST;
    else                      k = KIND_OTHER;
    return k;
  endfunction

endpackage

// File: rtl/flash_wel_sync.sv
module flash_wel_sync #(
  parameter int          STAGES  = 2,
  parameter logic        RST_VAL = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d_async,
  output logic q_sync
);

  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  generate
    if (STAGES == 1) begin : g_one
      always_comb chain_d = d_async;
    end else begin : g_many
      always_comb chain_d = {chain_q[STAGES-2:0], d_async};
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= {STAGES{RST_VAL}};
    else        chain_q <= chain_d;
  end

  assign q_sync = chain_q[STAGES-1];

endmodule

// File: rtl/flash_wel_frame.sv
module flash_wel_frame
  import flash_wel_pkg::*;
#(
  parameter logic [7:0] WREN_OPC = 8'h06,
  parameter logic [7:0] WRDI_OPC = 8'h04,
  parameter logic [7:0] RST_OPC  = 8'hF0
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       opc_done,
  input  logic [7:0] opc_byte,
  input  logic       opc_is_mod,
  input  logic       cs_rise,
  output cmd_kind_e  now_kind,
  output logic       frame_ok,
  output cmd_kind_e  frame_kind
);

  logic      ok_d;
  cmd_kind_e kind_d;
  logic      upd_en;

  always_comb begin
    now_kind = classify(opc_is_mod, opc_byte, WREN_OPC, WRDI_OPC, RST_OPC);
  end

  always_comb begin
    upd_en = cs_rise | opc_done;
    ok_d   = frame_ok;
    kind_d = frame_kind;
    if (cs_rise) begin
      ok_d   = 1'b0;
      kind_d = KIND_NONE;
    end else if (opc_done) begin
      ok_d   = 1'b1;
      kind_d = now_kind;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      frame_ok   <= 1'b0;
      frame_kind <= KIND_NONE;
    end else if (upd_en) begin
      frame_ok   <= ok_d;
      frame_kind <= kind_d;
    end
  end

endmodule

// File: rtl/flash_wel_latch.sv
module flash_wel_latch
  import flash_wel_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      opc_done,
  input  cmd_kind_e now_kind,
  input  logic      frame_ok,
  input  cmd_kind_e frame_kind,
  input  logic      op_complete,
  input  logic      op_abort,
  input  logic      hold_abort,
  input  logic      sr2_wr,
  input  logic      sr2_din,
  output logic      wel,
  output logic      rst_en,
  output logic      mod_grant,
  output logic      mod_reject,
  output logic      soft_rst
);

  logic wel_d, rst_en_d;
  logic grant_d, reject_d, soft_d;
  logic set_ev, clr_ev;
  logic op_end;

  always_comb begin
    op_end   = op_complete | op_abort;
    soft_d   = opc_done & (now_kind == KIND_RST) & rst_en;
    grant_d  = opc_done & (now_kind == KIND_MOD) & wel;
    reject_d = opc_done & (now_kind == KIND_MOD) & ~wel;
    set_ev   = frame_ok & op_complete & (frame_kind == KIND_WREN);
    clr_ev   = (frame_ok & op_end & (frame_kind == KIND_MOD))
             | (frame_ok & op_complete & (frame_kind == KIND_WRDI))
             | hold_abort
             | soft_d;
    wel_d = wel;
    if (set_ev) wel_d = 1'b1;
    if (clr_ev) wel_d = 1'b0;
    rst_en_d = sr2_wr ? sr2_din : rst_en;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wel        <= 1'b0;
      rst_en     <= 1'b0;
      mod_grant  <= 1'b0;
      mod_reject <= 1'b0;
      soft_rst   <= 1'b0;
    end else begin
      wel        <= wel_d;
      mod_grant  <= grant_d;
      mod_reject <= reject_d;
      soft_rst   <= soft_d;
      if (sr2_wr) rst_en <= rst_en_d;
    end
  end

endmodule

// File: rtl/flash_wel_swp.sv
module flash_wel_swp
  import flash_wel_pkg::*;
#(
  parameter int NSECT = 16
) (
  input  logic [NSECT-1:0] sect_prot,
  output logic [1:0]       swp_sum
);

  logic [NSECT:0] any_c;
  logic [NSECT:0] all_c;

  assign any_c[0] = 1'b0;
  assign all_c[0] = 1'b1;

  generate
    for (genvar i = 0; i < NSECT; i++) begin : g_red
      assign any_c[i+1] = any_c[i] | sect_prot[i];
      assign all_c[i+1] = all_c[i] & sect_prot[i];
    end
  endgenerate

  always_comb begin
    if (all_c[NSECT])      swp_sum = SWP_ALL;
    else if (any_c[NSECT]) swp_sum = SWP_SOME;
    else                   swp_sum = SWP_NONE;
  end

endmodule

// File: rtl/flash_wel_status.sv
module flash_wel_status
  import flash_wel_pkg::*;
#(
  parameter int         NSECT       = 16,
  parameter int         SYNC_STAGES = 2,
  parameter int         RST_STAGES  = 2,
  parameter logic [7:0] WREN_OPC    = 8'h06,
  parameter logic [7:0] WRDI_OPC    = 8'h04,
  parameter logic [7:0] RST_OPC     = 8'hF0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             opc_done,
  input  logic [7:0]       opc_byte,
  input  logic             opc_is_mod,
  input  logic             op_complete,
  input  logic             op_abort,
  input  logic             hold_abort,
  input  logic             cs_rise,
  input  logic             sr2_wr,
  input  logic             sr2_din,
  input  logic             wp_pin_n,
  input  logic [NSECT-1:0] sect_prot,
  output logic             wel,
  output logic             rst_en,
  output logic             wp_stat,
  output logic [1:0]       swp_sum,
  output logic             mod_grant,
  output logic             mod_reject,
  output logic             soft_rst
);

  logic      rst_sync_n;
  logic      wp_pin_s;
  cmd_kind_e now_kind;
  cmd_kind_e frame_kind;
  logic      frame_ok;

  flash_wel_sync #(.STAGES(RST_STAGES), .RST_VAL(1'b0)) u_rst_sync (
    .clk     (clk),
    .rst_n   (rst_n),
    .d_async (1'b1),
    .q_sync  (rst_sync_n)
  );

  flash_wel_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_wp_sync (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .d_async (wp_pin_n),
    .q_sync  (wp_pin_s)
  );

  assign wp_stat = ~wp_pin_s;

  flash_wel_frame #(
    .WREN_OPC (WREN_OPC),
    .WRDI_OPC (WRDI_OPC),
    .RST_OPC  (RST_OPC)
  ) u_frame (
    .clk        (clk),
    .rst_n      (rst_sync_n),
    .opc_done   (opc_done),
    .opc_byte   (opc_byte),
    .opc_is_mod (opc_is_mod),
    .cs_rise    (cs_rise),
    .now_kind   (now_kind),
    .frame_ok   (frame_ok),
    .frame_kind (frame_kind)
  );

  flash_wel_latch u_latch (
    .clk         (clk),
    .rst_n       (rst_sync_n),
    .opc_done    (opc_done),
    .now_kind    (now_kind),
    .frame_ok    (frame_ok),
    .frame_kind  (frame_kind),
    .op_complete (op_complete),
    .op_abort    (op_abort),
    .hold_abort  (hold_abort),
    .sr2_wr      (sr2_wr),
    .sr2_din     (sr2_din),
    .wel         (wel),
    .rst_en      (rst_en),
    .mod_grant   (mod_grant),
    .mod_reject  (mod_reject),
    .soft_rst    (soft_rst)
  );

  flash_wel_swp #(.NSECT(NSECT)) u_swp (
    .sect_prot (sect_prot),
    .swp_sum   (swp_sum)
  );

endmodule

// File: rtl/flash_wel_status_chk.sv
module flash_wel_status_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       op_complete,
  input logic       hold_abort,
  input logic       sr2_wr,
  input logic       wel,
  input logic       rst_en,
  input logic [1:0] swp_sum,
  input logic       mod_grant,
  input logic       mod_reject,
  input logic       soft_rst
);

  AST_GRANT_NEEDS_WEL: assert property (@(posedge clk) disable iff (!rst_n)
    mod_grant |-> $past(wel)) else $error("grant without latch"); // R3

  AST_REJECT_NEEDS_NO_WEL: assert property (@(posedge clk) disable iff (!rst_n)
    mod_reject |-> !$past(wel)) else $error("reject with latch set"); // R3

  AST_WEL_RISE_ON_COMPLETE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(wel) |-> $past(op_complete)) else $error("latch set without completion"); // R2

  AST_HOLD_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    hold_abort |=> !wel) else $error("hold abort kept latch"); // R6

  AST_SOFT_RST_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    soft_rst |-> ($past(rst_en) && rst_en && !wel)) else $error("soft reset misbehaved"); // R7

  AST_RSTEN_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    !sr2_wr |=> $stable(rst_en)) else $error("reset enable changed"); // R8

  AST_SWP_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
    swp_sum != 2'b10) else $error("illegal summary code"); // R9

endmodule

bind flash_wel_status flash_wel_status_chk u_chk (.*);

// File: tb/flash_wel_status_bench.sv
module flash_wel_status_bench;

  localparam int CLK_PERIOD = 10;
  localparam int NS = 4;
  localparam int SYNC = 2;
  localparam logic [7:0] RSTOP = 8'hF0;

  logic clk = 1'b0;
  logic rst_n;
  logic opc_done, opc_is_mod, op_complete, op_abort, hold_abort, cs_rise;
  logic sr2_wr, sr2_din, wp_pin_n;
  logic [7:0] opc_byte;
  logic [NS-1:0] sect_prot;
  logic wel, rst_en, wp_stat, mod_grant, mod_reject, soft_rst;
  logic [1:0] swp_sum;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  flash_wel_status #(.NSECT(NS), .SYNC_STAGES(SYNC), .RST_OPC(RSTOP)) u_flash_wel_status (
    .clk(clk), .rst_n(rst_n), .opc_done(opc_done), .opc_byte(opc_byte),
    .opc_is_mod(opc_is_mod), .op_complete(op_complete), .op_abort(op_abort),
    .hold_abort(hold_abort), .cs_rise(cs_rise), .sr2_wr(sr2_wr), .sr2_din(sr2_din),
    .wp_pin_n(wp_pin_n), .sect_prot(sect_prot), .wel(wel), .rst_en(rst_en),
    .wp_stat(wp_stat), .swp_sum(swp_sum), .mod_grant(mod_grant),
    .mod_reject(mod_reject), .soft_rst(soft_rst)
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic cyc();
    @(posedge clk);
    #1;
  endtask

  task automatic send_opc(input logic [7:0] code, input logic is_mod);
    opc_done = 1'b1; opc_byte = code; opc_is_mod = is_mod;
    cyc();
    opc_done = 1'b0; opc_is_mod = 1'b0;
  endtask

  task automatic pulse_end(input int which);
    if (which == 0) op_complete = 1'b1; else op_abort = 1'b1;
    cyc();
    op_complete = 1'b0; op_abort = 1'b0;
  endtask

  task automatic pulse_cs();
    cs_rise = 1'b1; cyc(); cs_rise = 1'b0;
  endtask

  task automatic force_wel(input logic v);
    send_opc(v ? 8'h06 : 8'h04, 1'b0);
    pulse_end(0);
    pulse_cs();
  endtask

  initial begin
    logic [7:0] codes [4];
    rst_n = 1'b0;
    opc_done = 0; opc_is_mod = 0; op_complete = 0; op_abort = 0; hold_abort = 0;
    cs_rise = 0; sr2_wr = 0; sr2_din = 0; wp_pin_n = 1'b1; opc_byte = 8'h00;
    sect_prot = '0;
    codes[0] = 8'h06; codes[1] = 8'h04; codes[2] = 8'h02; codes[3] = 8'h03;
    repeat (3) cyc();
    check("R1 wel in reset", int'(wel), 0);
    check("R1 rst_en in reset", int'(rst_en), 0);
    check("R1 pulses in reset", int'({mod_grant, mod_reject, soft_rst}), 0);
    check("R1 wp_stat in reset", int'(wp_stat), 0);
    rst_n = 1'b1;
    repeat (4) cyc();
    check("R1 wel after release", int'(wel), 0);
    check("R1 rst_en after release", int'(rst_en), 0);

    // R2 R3 R4 R5 R11 sweep: start value x class x end event x qualified
    for (int w = 0; w < 2; w++)
      for (int k = 0; k < 4; k++)
        for (int e = 0; e < 2; e++)
          for (int q = 0; q < 2; q++) begin
            int expw;
            string tag;
            force_wel(logic'(w));
            check("R2 setup latch", int'(wel), w);
            if (q == 1) begin
              send_opc(codes[k], k == 2);
              if (k == 2) begin
                check("R3 grant", int'(mod_grant), w);
                check("R3 reject", int'(mod_reject), 1 - w);
              end else begin
                check("R3 no pulse for other class", int'({mod_grant, mod_reject}), 0);
              end
            end
            pulse_end(e);
            if (q == 0) begin expw = w; tag = "R5 unqualified end"; end
            else if (k == 0) begin expw = (e == 0) ? 1 : w; tag = "R2 write enable"; end
            else if (k == 1) begin expw = (e == 0) ? 0 : w; tag = "R2 write disable"; end
            else if (k == 2) begin expw = 0; tag = "R4 modify end"; end
            else begin expw = w; tag = "R11 other class"; end
            check(tag, int'(wel), expw);
            pulse_cs();
          end

    // R6 hold abort
    force_wel(1'b1);
    hold_abort = 1'b1; cyc(); hold_abort = 1'b0;
    check("R6 hold abort clears", int'(wel), 0);

    // R7 soft reset disabled
    force_wel(1'b1);
    send_opc(RSTOP, 1'b0);
    check("R7 disabled reset no pulse", int'(soft_rst), 0);
    cyc();
    check("R7 disabled reset keeps wel", int'(wel), 1);
    pulse_cs();

    // R8 write reset enable
    sr2_din = 1'b1; sr2_wr = 1'b1; cyc(); sr2_wr = 1'b0;
    check("R8 rst_en written", int'(rst_en), 1);
    sr2_din = 1'b0; repeat (3) cyc();
    check("R8 rst_en holds without write", int'(rst_en), 1);

    // R7 soft reset enabled
    send_opc(RSTOP, 1'b0);
    check("R7 soft reset pulse", int'(soft_rst), 1);
    check("R7 soft reset clears wel", int'(wel), 0);
    check("R7 soft reset keeps rst_en", int'(rst_en), 1);
    cyc();
    check("R7 pulse one cycle", int'(soft_rst), 0);
    pulse_cs();
    sr2_din = 1'b0; sr2_wr = 1'b1; cyc(); sr2_wr = 1'b0;
    check("R8 rst_en cleared by write", int'(rst_en), 0);

    // R9 summary sweep
    for (int v = 0; v < (1 << NS); v++) begin
      int expv;
      sect_prot = NS'(v);
      #1;
      expv = (v == 0) ? 0 : ((v == (1 << NS) - 1) ? 3 : 1);
      check("R9 protection summary", int'(swp_sum), expv);
    end

    // R10 pin synchroniser latency
    wp_pin_n = 1'b0;
    for (int s = 1; s <= SYNC; s++) begin
      cyc();
      check("R10 wp_stat latency", int'(wp_stat), (s >= SYNC) ? 1 : 0);
    end
    wp_pin_n = 1'b1;
    repeat (SYNC) cyc();
    check("R10 wp_stat released", int'(wp_stat), 0);

    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule